// File: doc/BRIEF.md
# Double-Buffered Serial Code Register for a 12-Bit Voltage DAC

This block is the digital front end of a 12-bit voltage-output converter. A host sends a code over a three-wire serial port (serial clock, serial data, active-low select) into a shift register. An active-low load strobe then moves the collected word into a second register. That second register drives the 12-bit code output, which stands in for the analog ladder. One LSB is 0.5 mV: code 000h is zero scale, 800h is mid-scale (1.024 V) and FFFh is 2.0475 V. Because there are two stages, the next code can be shifted in while the output keeps its present value.

The block runs on a fast system clock. The serial pins and the load strobe pass through a synchronizer of `SYNC_STAGES` flops. A rising serial-clock edge is detected in the clock domain. The code register is transparent: while the synchronized load is low, it copies the shift register on every clock, and it holds its value while load is high. An active-low clear forces the code to zero at once, with no clock, and it overrides load. A rising serial clock that arrives while load is low breaks the protocol. The block does not shift on such an edge and raises a one-cycle flag instead.

Top module: `serial_dac_frontend`

## Requirements
- R1: After `rst_n` is released, `code` is 000h and `proto_err` is 0.
- R2: Each synchronized rising edge of `sclk` with `sel_n` low and `load_n` high shifts `sdi` in at bit 0. The word arrives MSB first, and the last 12 bits shifted in form the word.
- R3: While `sel_n` is high, `sclk` edges leave the shift register unchanged.
- R4: When `load_n` falls, `code` takes the shift-register contents, even when `sel_n` is high.
- R5: While `load_n` stays high, `code` holds its value whatever happens on the serial port.
- R6: While `load_n` is low and `clr_n` is high, `code` follows the shift register one clock behind it.
- R7: `clr_n` low forces `code` to 000h at once, without a clock edge, whatever the level of `load_n`.
- R8: When `clr_n` returns high while `load_n` is high, `code` stays at 000h.
- R9: Clear leaves the shift register as it was. A later load restores the word that was shifted in before the clear.
- R10: A rising `sclk` edge while `sel_n` and `load_n` are both low does not shift. It drives `proto_err` high for exactly one clock.
- R11: The codes 000h, 800h and FFFh pass through unchanged. This covers the all-zero, single-MSB and all-one patterns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low select; enables shifting only |
| sclk | input | 1 | Serial clock; data is taken on its rising edge |
| sdi | input | 1 | Serial data, MSB first |
| load_n | input | 1 | Active-low load strobe; code register is transparent while low |
| clr_n | input | 1 | Asynchronous active-low clear of the code register |
| code | output | 12 | Held converter code |
| proto_err | output | 1 | One-cycle pulse on a serial edge taken while load is low |

## Verification
The bench loads a word and then shifts a second word without a load. A design without a real second stage would show the half-shifted word on `code`. It sends a word with select high and then strobes load. If select gated the load path, `code` would not update; if select did not gate shifting, `code` would show the wrong word. It pulses clear with load low, then with load high, and finally strobes load with no new data. These steps expose a clear that waits for a clock, a clear that loses to load, and a clear that also wipes the shift register. A serial edge taken while load is low must raise the flag without moving any bit. The bench also shifts more than 12 bits, which catches bit order reversed or an LSB-first shifter.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
  typedef struct packed {
    logic sclk;
    logic sel_n;
    logic load_n;
    logic sdi;
  } ser_pins_t;

  localparam ser_pins_t PINS_IDLE = '{sclk: 1'b0, sel_n: 1'b1, load_n: 1'b1, sdi: 1'b0};
endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
  parameter int              STAGES  = 2,
  parameter int              W       = 4,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q = d;
    end else begin : g_chain
      logic [W-1:0] stage_q [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
        end else begin
          stage_q[0] <= d;
          for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
      end
      assign q = stage_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/dacfe_shifter.sv
module dacfe_shifter
  import dacfe_pkg::*;
#(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ser_pins_t        pins,
  output logic [WIDTH-1:0] shift_q,
  output logic             proto_err
);
  logic             sclk_prev_q;
  logic             rise;
  logic             shift_en;
  logic             err_d;
  logic [WIDTH-1:0] shift_d;

  always_comb begin
    rise     = pins.sclk & ~sclk_prev_q;
    shift_en = rise & ~pins.sel_n & pins.load_n;
    err_d    = rise & ~pins.sel_n & ~pins.load_n;
    shift_d  = {shift_q[WIDTH-2:0], pins.sdi};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev_q <= 1'b0;
      proto_err   <= 1'b0;
    end else begin
      sclk_prev_q <= pins.sclk;
      proto_err   <= err_d;
    end
  end

  // Data path register: no reset, contents undefined until a full word arrives.
  always_ff @(posedge clk) begin
    if (shift_en) shift_q <= shift_d;
  end
endmodule

// File: rtl/dacfe_hold.sv
module dacfe_hold #(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic             upd_en;
  logic [WIDTH-1:0] dout_d;

  always_comb begin
    upd_en = ~load_n;
    dout_d = upd_en ? din : dout;
  end

  always_ff @(posedge clk or negedge rst_n or negedge clr_n) begin
    if (!rst_n)      dout <= '0;
    else if (!clr_n) dout <= '0;
    else             dout <= dout_d;
  end
endmodule

// File: rtl/serial_dac_frontend.sv
module serial_dac_frontend
  import dacfe_pkg::*;
#(
  parameter int WIDTH       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_n,
  input  logic             sclk,
  input  logic             sdi,
  input  logic             load_n,
  input  logic             clr_n,
  output logic [WIDTH-1:0] code,
  output logic             proto_err
);
  localparam int PIN_W = $bits(ser_pins_t);

  ser_pins_t        pins_raw;
  ser_pins_t        pins_s;
  logic [WIDTH-1:0] shift_q;
  logic             sel_s;
  logic             load_s;

  assign pins_raw = '{sclk: sclk, sel_n: sel_n, load_n: load_n, sdi: sdi};

  dacfe_sync #(
    .STAGES (SYNC_STAGES),
    .W      (PIN_W),
    .RST_VAL(PINS_IDLE)
  ) sync_i (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pins_raw),
    .q    (pins_s)
  );

  assign sel_s  = pins_s.sel_n;
  assign load_s = pins_s.load_n;

  dacfe_shifter #(.WIDTH(WIDTH)) shift_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .pins     (pins_s),
    .shift_q  (shift_q),
    .proto_err(proto_err)
  );

  dacfe_hold #(.WIDTH(WIDTH)) hold_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_n (clr_n),
    .load_n(load_s),
    .din   (shift_q),
    .dout  (code)
  );
endmodule

// File: rtl/dacfe_checker.sv
module dacfe_checker #(
  parameter int WIDTH = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr_n,
  input logic [WIDTH-1:0] code,
  input logic             proto_err,
  input logic [WIDTH-1:0] shift_q,
  input logic             sel_s,
  input logic             load_s
);
  a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> code == '0);

  a_r5_hold_when_high: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    $past(load_s) |-> $stable(code));

  a_r6_transparent: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    (!$past(load_s) && $past(clr_n)) |-> code == $past(shift_q));

  a_r3_sel_blocks_shift: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sel_s) |-> $stable(shift_q));

  a_r10_err_no_shift: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> $stable(shift_q));

  a_r10_err_single: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> !proto_err);
endmodule

bind serial_dac_frontend dacfe_checker #(.WIDTH(WIDTH)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .clr_n    (clr_n),
  .code     (code),
  .proto_err(proto_err),
  .shift_q  (shift_q),
  .sel_s    (sel_s),
  .load_s   (load_s)
);

// File: tb/serial_dac_frontend_tb_top.sv
`timescale 1ns/1ps
module serial_dac_frontend_tb_top;
  localparam int W  = 12;
  localparam int SS = 2;

  logic clk = 1'b0;
  logic rst_n, sel_n, sclk, sdi, load_n, clr_n;
  logic [W-1:0] code;
  logic proto_err;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;
  bit seen_err = 0;

  always #5 clk = ~clk;

  serial_dac_frontend #(.WIDTH(W), .SYNC_STAGES(SS)) dut_i (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk), .sdi(sdi),
    .load_n(load_n), .clr_n(clr_n), .code(code), .proto_err(proto_err)
  );

  // Behavioural reference: input delay queue plus integer state.
  logic [3:0] pipe[$];          // {sclk, sel_n, load_n, sdi}
  int  m_sh, m_code, m_bits;
  bit  m_prev, m_err, m_ok;

  always @(negedge clr_n) begin
    m_code = 0;
    m_ok   = 1;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe.delete();
      for (int i = 0; i < SS; i++) pipe.push_back(4'b0110);
      m_prev = 0; m_err = 0; m_code = 0; m_ok = 1; m_bits = 0; m_sh = 0;
    end else begin
      logic [3:0] s;
      bit rise;
      int old_sh;
      s      = pipe[0];
      old_sh = m_sh;
      rise   = s[3] && !m_prev;
      m_err  = rise && !s[2] && !s[1];
      if (rise && !s[2] && s[1]) begin
        m_sh = ((m_sh << 1) | s[0]) & 'hFFF;
        m_bits++;
      end
      if (!clr_n) begin
        m_code = 0; m_ok = 1;
      end else if (!s[1]) begin
        m_code = old_sh;
        m_ok   = (m_bits >= W);
      end
      m_prev = s[3];
      void'(pipe.pop_front());
      pipe.push_back({sclk, sel_n, load_n, sdi});
    end
  end

  task automatic check(string tag, int act, int exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%03h expected=%03h", tag, act, exp);
    end
  endtask

  // Every-clock comparison against the reference (R5 R6 R7 R10).
  always @(negedge clk) begin
    if (proto_err === 1'b1) seen_err = 1;
    if (rst_n === 1'b1 && !done) begin
      if (m_ok) check("R5/R6/R7 per-clock code", int'(code), m_code);
      check("R10 per-clock proto_err", int'(proto_err), int'(m_err));
    end
  end

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic shift_bits(int val, int nbits, bit sel);
    for (int i = nbits - 1; i >= 0; i--) begin
      wait_clk(1);
      sel_n = sel; sdi = val[i]; sclk = 0;
      wait_clk(3);
      sclk = 1;
      wait_clk(3);
      sclk = 0;
    end
    wait_clk(2);
    sel_n = 1;
    wait_clk(4);
  endtask

  task automatic load_pulse();
    wait_clk(1);
    load_n = 0;
    wait_clk(6);
    load_n = 1;
    wait_clk(5);
  endtask

  initial begin
    #1_000_000;
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    rst_n = 0; sel_n = 1; sclk = 0; sdi = 0; load_n = 1; clr_n = 1;
    wait_clk(4);
    rst_n = 1;
    wait_clk(3);
    check("R1 reset code", int'(code), 0);
    check("R1 reset proto_err", int'(proto_err), 0);

    shift_bits('hA5C, W, 0);
    load_pulse();
    check("R2 R4 load A5C", int'(code), 'hA5C);

    shift_bits('h3E7, W, 1);                  // select high: ignored
    check("R5 hold during deselected shift", int'(code), 'hA5C);
    load_pulse();
    check("R3 R4 load after deselected shift", int'(code), 'hA5C);

    shift_bits('h123, W, 0);
    check("R5 double buffer holds", int'(code), 'hA5C);
    wait_clk(1); sel_n = 1; load_n = 0;       // load with select high
    wait_clk(6);
    check("R4 R6 transparent with sel high", int'(code), 'h123);

    clr_n = 0; #1;
    check("R7 async clear with load low", int'(code), 0);
    wait_clk(4);
    check("R7 clear priority over load", int'(code), 0);
    clr_n = 1;
    wait_clk(4);
    check("R6 transparent after clear release", int'(code), 'h123);

    // R10: serial edge while load low
    seen_err = 0;
    sel_n = 0; sdi = 1; sclk = 1;
    wait_clk(6);
    sclk = 0; sel_n = 1;
    wait_clk(4);
    check("R10 proto_err pulsed", int'(seen_err), 1);
    check("R10 no shift while load low", int'(code), 'h123);
    load_n = 1;
    wait_clk(5);

    wait_clk(1); clr_n = 0; #1;
    check("R7 async clear with load high", int'(code), 0);
    wait_clk(4); clr_n = 1;
    wait_clk(6);
    check("R8 zero stays after release", int'(code), 0);
    load_pulse();
    check("R9 shift register kept through clear", int'(code), 'h123);

    shift_bits('hFFF, W, 0); load_pulse();
    check("R11 full scale FFF", int'(code), 'hFFF);
    shift_bits('h800, W, 0); load_pulse();
    check("R11 mid scale 800", int'(code), 'h800);
    shift_bits('h000, W, 0); load_pulse();
    check("R11 zero scale 000", int'(code), 0);

    shift_bits('hB7A6, 16, 0); load_pulse();  // last 12 bits retained
    check("R2 MSB first, last 12 bits kept", int'(code), 'h7A6);
    shift_bits('h5, 3, 0); load_pulse();      // partial word shifts on
    check("R2 partial word shifts in", int'(code), 'hD35);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule